// File: doc/BRIEF.md
# Automatic Level Control Attack Sequencer with Peak Limiter

This block steps a programmable-gain-amplifier gain index from a stream of signed converter samples. Each sample arrives with a one-cycle strobe. A sample counts as loud when its magnitude reaches a programmable level. Loud samples pull the gain index down by one step each time an attack interval, counted in strobes, has elapsed. The attack interval comes from a 4-bit attack code and a 3-bit rate select. The base count is fixed for the highest rate and scales down for slower rates. Each attack-code step doubles the interval.

A fast limiter is built in. Any sample above seven eighths of positive full scale makes the sequencer use the shortest interval, the same as attack code 0, and raises a flag. When the signal has stayed quiet for a hold period, the gain climbs one step per decay period up to a ceiling. With the level control disabled, the gain index follows a fixed value from an input port and the limiter flag is held low.

Top module: `alc_gain_seq`

## Requirements
- R1: While reset is asserted, `gain_idx` equals parameter GAIN_MAX and `limit_act` is 0.
- R2: While `alc_en` is 0, `gain_idx` takes the value of `fixed_gain` on the next clock and `limit_act` is 0, whatever samples arrive.
- R3: A sample is loud when its magnitude is at least ATK_LEVEL. Each loud sample advances an attack counter. On the loud strobe that completes the interval, the gain drops by one and the counter restarts. The interval is base(rate) << code. base is ATK_BASE48 for rate 000, 2/3 of it for 001, 1/2 for 010, 1/3 for 011, 1/4 for 100 and 1/6 for 101.
- R4: Attack codes from 10 (1010) to 15 give exactly the interval of code 10.
- R5: Rate codes 110 and 111 use the 000 base.
- R6: A sample whose magnitude exceeds floor(7 × (2^(W−1)−1) / 8) uses the code-0 interval. `limit_act` is then 1 from the clock that registers that strobe. It returns to 0 at the first strobe whose sample is not above the threshold.
- R7: The most negative sample code counts as above the limiter threshold.
- R8: The gain index stops at 0 and never wraps.
- R9: A sample below ATK_LEVEL is quiet. Each quiet strobe clears the attack counter. After HOLD_SMP quiet strobes, every DECAY_SMP-th further quiet strobe raises the gain by one, up to GAIN_MAX.
- R10: A loud sample restarts both the hold count and the decay count.
- R11: With `alc_en` high and no strobe, `gain_idx` and `limit_act` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alc_en | input | 1 | Level control enable |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | SMP_W | Signed sample |
| atk_code | input | 4 | Attack-time code |
| rate_sel | input | 3 | Sample-rate select |
| fixed_gain | input | GAIN_W | Gain used while disabled |
| gain_idx | output | GAIN_W | Gain index |
| limit_act | output | 1 | Limiter active |

## Verification
The bench checks the interval at several rate and code pairs, including rate 001, where an integer-rounding mistake would shift the step timing. It runs one full code-10 interval with code 12, so a design that does not clamp the shift would skip the expected step. The limiter threshold is probed one code each side, and the most negative sample is included, since a magnitude computed with signed arithmetic would miss it. The bench drives the gain to 0 to check that it does not wrap to the top. It also places a single loud sample inside a hold window and requires the rise to be postponed; a design that skips the hold reset would raise the gain early.

// File: rtl/alc_pkg.sv
package alc_pkg;
    typedef enum logic [2:0] {
        RATE_48K = 3'd0,
        RATE_32K = 3'd1,
        RATE_24K = 3'd2,
        RATE_16K = 3'd3,
        RATE_12K = 3'd4,
        RATE_8K  = 3'd5
    } rate_e;

    localparam int ATK_CODE_SAT = 10;

    function automatic int rate_base(input logic [2:0] sel, input int base48);
        int b;
        case (sel)
            3'd1:    b = (base48 * 2) / 3;
            3'd2:    b = base48 / 2;
            3'd3:    b = base48 / 3;
            3'd4:    b = base48 / 4;
            3'd5:    b = base48 / 6;
            default: b = base48;
        endcase
        return (b < 1) ? 1 : b;
    endfunction
endpackage

// File: rtl/alc_interval_lut.sv
module alc_interval_lut #(
    parameter int ATK_BASE48 = 288,
    parameter int CNT_W      = 19
) (
    input  logic [3:0]       atk_code,
    input  logic [2:0]       rate_sel,
    output logic [CNT_W-1:0] norm_ival,
    output logic [CNT_W-1:0] fast_ival
);
    import alc_pkg::*;

    logic [CNT_W-1:0] base_d;
    logic [3:0]       shift_d;

    always_comb begin
        base_d    = CNT_W'(rate_base(rate_sel, ATK_BASE48));
        shift_d   = (int'(atk_code) >= ATK_CODE_SAT) ? 4'(ATK_CODE_SAT) : atk_code;
        norm_ival = base_d << shift_d;
        fast_ival = base_d;
    end

    // R4: saturated codes share the code-10 interval
    always_comb begin
        if (!$isunknown(atk_code) && !$isunknown(rate_sel) && atk_code >= 4'd10)
            p_sat_code_r4: assert (norm_ival == (fast_ival << 10));
    end
endmodule

// File: rtl/alc_peak_det.sv
module alc_peak_det #(
    parameter int SMP_W     = 16,
    parameter int ATK_LEVEL = 16384
) (
    input  logic [SMP_W-1:0] smp_data,
    output logic             over_thr,
    output logic             loud
);
    localparam longint MAX_POS = (longint'(1) <<< (SMP_W - 1)) - 1;
    localparam longint LIM_THR = (MAX_POS * 7) / 8;

    logic [SMP_W-1:0] mag_d;

    always_comb begin
        mag_d    = smp_data[SMP_W-1] ? (~smp_data + SMP_W'(1)) : smp_data;
        over_thr = longint'(mag_d) > LIM_THR;
        loud     = over_thr || (longint'(mag_d) >= longint'(ATK_LEVEL));
    end

    // R7: the most negative code must register as over threshold
    always_comb begin
        if (!$isunknown(smp_data) && smp_data == {1'b1, {(SMP_W-1){1'b0}}})
            p_neg_full_r7: assert (over_thr && loud);
    end
endmodule

// File: rtl/alc_gain_seq.sv
module alc_gain_seq #(
    parameter int SMP_W      = 16,
    parameter int GAIN_W     = 6,
    parameter int GAIN_MAX   = 40,
    parameter int ATK_BASE48 = 288,
    parameter int ATK_LEVEL  = 16384,
    parameter int HOLD_SMP   = 480,
    parameter int DECAY_SMP  = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alc_en,
    input  logic              smp_vld,
    input  logic [SMP_W-1:0]  smp_data,
    input  logic [3:0]        atk_code,
    input  logic [2:0]        rate_sel,
    input  logic [GAIN_W-1:0] fixed_gain,
    output logic [GAIN_W-1:0] gain_idx,
    output logic              limit_act
);
    localparam int CNT_W  = $clog2(ATK_BASE48 * 1024 + 1);
    localparam int HOLD_W = $clog2(HOLD_SMP + 1);
    localparam int DEC_W  = $clog2(DECAY_SMP + 1);

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        logic              lim;
        logic [CNT_W-1:0]  acnt;
        logic [HOLD_W-1:0] hcnt;
        logic [DEC_W-1:0]  dcnt;
    } seq_t;

    seq_t st_d, st_q;

    logic [CNT_W-1:0] norm_ival, fast_ival, ival_d;
    logic             over_thr, loud;

    alc_interval_lut #(.ATK_BASE48(ATK_BASE48), .CNT_W(CNT_W)) u_lut (
        .atk_code (atk_code),
        .rate_sel (rate_sel),
        .norm_ival(norm_ival),
        .fast_ival(fast_ival)
    );

    alc_peak_det #(.SMP_W(SMP_W), .ATK_LEVEL(ATK_LEVEL)) u_peak (
        .smp_data(smp_data),
        .over_thr(over_thr),
        .loud    (loud)
    );

    always_comb begin
        st_d   = st_q;
        ival_d = over_thr ? fast_ival : norm_ival;
        if (!alc_en) begin
            st_d.gain = fixed_gain;
            st_d.lim  = 1'b0;
            st_d.acnt = '0;
            st_d.hcnt = '0;
            st_d.dcnt = '0;
        end else if (smp_vld) begin
            st_d.lim = over_thr;
            if (loud) begin
                st_d.hcnt = '0;
                st_d.dcnt = '0;
                if (st_q.acnt + CNT_W'(1) >= ival_d) begin
                    st_d.acnt = '0;
                    if (st_q.gain != '0)
                        st_d.gain = st_q.gain - GAIN_W'(1);
                end else begin
                    st_d.acnt = st_q.acnt + CNT_W'(1);
                end
            end else begin
                st_d.acnt = '0;
                if (st_q.hcnt < HOLD_W'(HOLD_SMP)) begin
                    st_d.hcnt = st_q.hcnt + HOLD_W'(1);
                end else if (st_q.dcnt + DEC_W'(1) >= DEC_W'(DECAY_SMP)) begin
                    st_d.dcnt = '0;
                    if (st_q.gain < GAIN_W'(GAIN_MAX))
                        st_d.gain = st_q.gain + GAIN_W'(1);
                end else begin
                    st_d.dcnt = st_q.dcnt + DEC_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.gain <= GAIN_W'(GAIN_MAX);
        end else begin
            st_q <= st_d;
        end
    end

    assign gain_idx  = st_q.gain;
    assign limit_act = st_q.lim;

    // R2: limiter flag is low one clock after a disabled cycle
    p_lim_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !alc_en |=> !limit_act);

    // R11: no strobe, no change
    p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (alc_en && !smp_vld) |=> ($stable(gain_idx) && $stable(limit_act)));

    // R8: from zero the gain can only stay or rise by one
    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (alc_en && gain_idx == '0) |=> (gain_idx <= GAIN_W'(1)));

    // R6: limiter flag only rises on a strobe
    p_lim_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (alc_en && !smp_vld && !limit_act) |=> !limit_act);

    // R3: enabled gain moves by at most one step per clock
    p_one_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (alc_en && smp_vld) |=> (gain_idx == $past(gain_idx) ||
                                 gain_idx == $past(gain_idx) - GAIN_W'(1) ||
                                 gain_idx == $past(gain_idx) + GAIN_W'(1)));
endmodule

// File: tb/tb_alc_gain_seq.sv
module tb_alc_gain_seq;
    localparam int PER = 10;
    localparam int GMAX = 40;
    localparam int HOLD = 8;
    localparam int DEC = 4;
    localparam int THR = 28671;   // floor(7*32767/8)
    localparam int LVL = 16384;

    logic        clk = 0, rst_n = 0, alc_en = 0, smp_vld = 0;
    logic [15:0] smp_data = '0;
    logic [3:0]  atk_code = 4'd2;
    logic [2:0]  rate_sel = 3'd0;
    logic [5:0]  fixed_gain = 6'd17;
    logic [5:0]  gain_idx;
    logic        limit_act;

    alc_gain_seq #(.SMP_W(16), .GAIN_W(6), .GAIN_MAX(GMAX), .ATK_BASE48(12),
                   .ATK_LEVEL(LVL), .HOLD_SMP(HOLD), .DECAY_SMP(DEC)) dut (
        .clk(clk), .rst_n(rst_n), .alc_en(alc_en), .smp_vld(smp_vld),
        .smp_data(smp_data), .atk_code(atk_code), .rate_sel(rate_sel),
        .fixed_gain(fixed_gain), .gain_idx(gain_idx), .limit_act(limit_act));

    always #(PER/2) clk = ~clk;

    typedef struct { int g; bit l; string r; } exp_t;
    exp_t q[$];
    int checks = 0, errors = 0;
    string cur = "R1";
    int eg = GMAX, ac = 0, hc = 0, dc = 0;

    task automatic check(string r, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", r, act, exp, $time);
        end
    endtask

    function automatic int base_of(int rs);
        int t[8] = '{12, 8, 6, 4, 3, 2, 12, 12};
        return t[rs];
    endfunction

    task automatic send(int s);
        int mag, iv; bit ov, ld;
        @(negedge clk);
        smp_vld = 1; smp_data = 16'(s);
        mag = (s < 0) ? -s : s;
        ov = mag > THR; ld = ov || mag >= LVL;
        if (!alc_en) begin
            q.push_back('{int'(fixed_gain), 1'b0, cur});
            return;
        end
        iv = ov ? base_of(rate_sel)
                : base_of(rate_sel) << ((atk_code > 10) ? 10 : int'(atk_code));
        if (ld) begin
            hc = 0; dc = 0;
            if (ac + 1 >= iv) begin ac = 0; if (eg > 0) eg--; end
            else ac++;
        end else begin
            ac = 0;
            if (hc < HOLD) hc++;
            else if (dc + 1 >= DEC) begin dc = 0; if (eg < GMAX) eg++; end
            else dc++;
        end
        q.push_back('{eg, ov, cur});
    endtask

    task automatic idle(int n);
        @(negedge clk); smp_vld = 0;
        repeat (n - 1) @(negedge clk);
    endtask

    // monitor: compare each registered strobe result against the queue
    always @(posedge clk) begin
        if (rst_n && smp_vld) begin
            exp_t e;
            #(PER/4);
            if (q.size() == 0) begin
                checks++; errors++;
                $display("FAIL %s: actual=unexpected result expected=none", cur);
            end else begin
                e = q.pop_front();
                check({e.r, " gain"}, int'(gain_idx), e.g);
                check({e.r, " limit"}, int'(limit_act), int'(e.l));
            end
        end
    end

    task automatic finish_up;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_up();
    end

    initial begin
        int g0;
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 gain", int'(gain_idx), GMAX);
        check("R1 limit", int'(limit_act), 0);
        rst_n = 1;
        // R2 disabled: fixed gain, strobes ignored
        cur = "R2";
        repeat (2) @(negedge clk);
        check("R2 gain", int'(gain_idx), 17);
        repeat (5) send(31000);
        idle(2);
        check("R2 limit", int'(limit_act), 0);
        // enable
        @(negedge clk); alc_en = 1; eg = 17; ac = 0; hc = 0; dc = 0;
        // R3 basic interval, rate 000 code 0
        cur = "R3"; atk_code = 4'd0; rate_sel = 3'd0;
        repeat (30) send(20000);
        // R3 rate 001 code 2: 32 strobes per step
        atk_code = 4'd2; rate_sel = 3'd1;
        repeat (70) send(-20000);
        // R5 reserved rate
        cur = "R5"; atk_code = 4'd1; rate_sel = 3'd6;
        repeat (50) send(18000);
        rate_sel = 3'd7;
        repeat (25) send(18000);
        // R4 saturated code: code 12 behaves as 10 (12288 per step)
        cur = "R4"; rate_sel = 3'd0; atk_code = 4'd12;
        repeat (12300) send(17000);
        atk_code = 4'd15;
        repeat (20) send(17000);
        // R6 limiter with slow attack
        cur = "R6"; atk_code = 4'd3;
        repeat (30) send(30000);
        repeat (20) send(20000);
        // R7 boundaries and most negative code
        cur = "R7";
        send(-32768); send(-28672); send(28671); send(28672); send(-28671);
        idle(1);
        // R11 stability without strobes
        cur = "R11"; g0 = int'(gain_idx);
        idle(6);
        check("R11 gain", int'(gain_idx), g0);
        // R8 floor
        cur = "R8"; atk_code = 4'd0; rate_sel = 3'd5;
        repeat (100) send(32767);
        idle(1);
        check("R8 floor", int'(gain_idx), 0);
        // R10 hold restart
        cur = "R10"; atk_code = 4'd10;
        repeat (7) send(100);
        send(20000);
        repeat (8) send(100);
        idle(1);
        check("R10 no early rise", int'(gain_idx), 0);
        repeat (4) send(100);
        idle(1);
        check("R10 rise after hold", int'(gain_idx), 1);
        // R9 decay to ceiling
        cur = "R9";
        repeat (250) send(0);
        idle(1);
        check("R9 ceiling", int'(gain_idx), GMAX);
        // R2 disable again
        cur = "R2"; fixed_gain = 6'd5; alc_en = 0;
        idle(2);
        check("R2 refix", int'(gain_idx), 5);
        idle(2);
        check("R2 queue drained", q.size(), 0);
        finish_up();
    end
endmodule